// File: doc/BRIEF.md
# Sticky End-of-Discharge Voltage Monitor

The block watches a stream of 8-bit battery-voltage samples. All codes, both samples and thresholds, use the scale volts = 1.2 × code / 256. A host-writable threshold sets the first warning level. A second, final level lies a fixed 100 mV lower, which is 21 codes. Each level drives its own warning flag. A flag rises only after a run of consecutive low samples. Once it has risen, it stays high until reset. The final flag marks a failure condition, and the surrounding system uses it to blank the capacity display.

Each flag is produced by its own run-qualifier state machine. The machine has three states.
- `Q_CLEAR` means no low run is in progress.
- `Q_RUN` means a run is being counted.
- `Q_LATCHED` means the flag is set.

The transitions are as follows.
- *start*: `Q_CLEAR` goes to `Q_RUN` on a low sample.
- *extend*: `Q_RUN` stays in `Q_RUN` on a low sample that does not complete the run.
- *trip*: `Q_RUN` goes to `Q_LATCHED` on the low sample that completes the run.
- *break*: `Q_RUN` goes to `Q_CLEAR` on a sample at or above the threshold.
- *restart*: `Q_RUN` goes to `Q_CLEAR` on a threshold write.
- *hold*: `Q_LATCHED` stays in `Q_LATCHED` whatever arrives.

Only a synchronous reset leaves `Q_LATCHED`.

Top module: `eodv_monitor`

## Requirements
- R1: After reset, `thr_code` reads A2h (162, about 0.76 V), and `warn_first` and `warn_final` are 0.
- R2: A cycle with `thr_wr_en` high loads `thr_wr_data` into the threshold. `thr_code` shows the new value from the next cycle on. Without a write, `thr_code` does not change.
- R3: `warn_first` becomes 1 at the clock edge that captures the 8th consecutive valid sample with `smp_code < thr_code`. It is still 0 after the 7th such sample.
- R4: The final threshold is `thr_code - 21`, or 0 if `thr_code < 21`. `warn_final` becomes 1 at the edge that captures the 8th consecutive valid sample below the final threshold.
- R5: A valid sample at or above a level's threshold restarts that level's run. After such a sample, 8 further low samples are needed.
- R6: Cycles with `smp_valid` low neither count toward a run nor break it.
- R7: A flag that is 1 stays 1 whatever samples or threshold writes follow, until `rst`.
- R8: A threshold write restarts both runs. A sample presented in the same cycle as the write is not counted. Flags that are already set are unaffected by the write.
- R9: With `thr_code` below 21, the final threshold is 0 and `warn_final` cannot be set, even by samples of code 0.
- R10: A sample equal to a threshold is not low for that level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Strobe: `smp_code` holds a new voltage sample |
| smp_code | input | 8 | Voltage sample code |
| thr_wr_en | input | 1 | Threshold write strobe |
| thr_wr_data | input | 8 | New first-threshold code |
| thr_code | output | 8 | Present first-threshold code |
| warn_first | output | 1 | Latched first end-of-discharge warning |
| warn_final | output | 1 | Latched final end-of-discharge warning |

## Verification
The bench builds the block with its default parameters: 8-bit codes, a run length of 8, a reset threshold of A2h and a 21-code final offset. With these values the default levels land on codes 162 and 141. Samples between these two codes can therefore trip the first flag alone. Writing threshold codes of 20 and 22 reaches both sides of the zero clamp on the final level. A run length of 8 keeps the off-by-one edges (7 versus 8 samples) cheap to reach in a few dozen cycles.

// File: rtl/eodv_pkg.sv
package eodv_pkg;

    // Number of monitored levels and their indices.
    localparam int unsigned NUM_LEVELS = 2;
    localparam int unsigned LVL_FIRST  = 0;
    localparam int unsigned LVL_FINAL  = 1;

    // Run-qualifier states.
    typedef enum logic [1:0] {
        Q_CLEAR   = 2'd0,
        Q_RUN     = 2'd1,
        Q_LATCHED = 2'd2
    } qual_state_t;

endpackage

// File: rtl/eodv_thresh_reg.sv
module eodv_thresh_reg #(
    parameter int unsigned        CODE_W       = 8,
    parameter logic [CODE_W-1:0]  THR_RESET    = 8'hA2,
    parameter int unsigned        FINAL_OFFSET = 21
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_data,
    output logic [CODE_W-1:0] thr_first,
    output logic [CODE_W-1:0] thr_final
);

    localparam logic [CODE_W-1:0] OFFSET_CODE = CODE_W'(FINAL_OFFSET);

    logic [CODE_W-1:0] thr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q <= THR_RESET;
        end else if (wr_en) begin
            thr_q <= wr_data;
        end
    end

    // Final level sits a fixed number of codes lower, floored at zero.
    always_comb begin
        thr_first = thr_q;
        if (thr_q >= OFFSET_CODE) begin
            thr_final = thr_q - OFFSET_CODE;
        end else begin
            thr_final = '0;
        end
    end

endmodule

// File: rtl/eodv_run_qual.sv
module eodv_run_qual
    import eodv_pkg::*;
#(
    parameter int unsigned RUN_LEN = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic sample_ok,
    input  logic is_low,
    input  logic restart,
    output logic tripped
);

    localparam int unsigned     CNT_W     = $clog2(RUN_LEN + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(RUN_LEN - 1);

    qual_state_t      state_q, state_nx;
    logic [CNT_W-1:0] count_q, count_nx;
    logic             low_seen;
    logic             high_seen;

    // A sample that coincides with a restart is discarded.
    assign low_seen  = sample_ok && is_low  && !restart;
    assign high_seen = sample_ok && !is_low && !restart;

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= Q_CLEAR;
            count_q <= '0;
        end else begin
            state_q <= state_nx;
            count_q <= count_nx;
        end
    end

    // Next-state logic.
    always_comb begin
        state_nx = state_q;
        count_nx = count_q;
        unique case (state_q)
            Q_CLEAR: begin
                if (low_seen) begin
                    if (RUN_LEN <= 1) begin
                        state_nx = Q_LATCHED;          // trip
                    end else begin
                        state_nx = Q_RUN;              // start
                        count_nx = CNT_W'(1);
                    end
                end
            end
            Q_RUN: begin
                if (restart || high_seen) begin
                    state_nx = Q_CLEAR;                // restart / break
                    count_nx = '0;
                end else if (low_seen) begin
                    if (count_q == LAST_CNT) begin
                        state_nx = Q_LATCHED;          // trip
                        count_nx = '0;
                    end else begin
                        count_nx = count_q + 1'b1;     // extend
                    end
                end
            end
            Q_LATCHED: begin
                state_nx = Q_LATCHED;                  // hold
            end
            default: begin
                state_nx = Q_CLEAR;
                count_nx = '0;
            end
        endcase
    end

    // Output logic.
    always_comb begin
        tripped = (state_q == Q_LATCHED);
    end

endmodule

// File: rtl/eodv_monitor.sv
module eodv_monitor
    import eodv_pkg::*;
#(
    parameter int unsigned        CODE_W       = 8,
    parameter int unsigned        RUN_LEN      = 8,
    parameter logic [CODE_W-1:0]  THR_RESET    = 8'hA2,
    parameter int unsigned        FINAL_OFFSET = 21
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid,
    input  logic [CODE_W-1:0] smp_code,
    input  logic              thr_wr_en,
    input  logic [CODE_W-1:0] thr_wr_data,
    output logic [CODE_W-1:0] thr_code,
    output logic              warn_first,
    output logic              warn_final
);

    logic [CODE_W-1:0]     level_thr [NUM_LEVELS];
    logic [NUM_LEVELS-1:0] level_trip;

    eodv_thresh_reg #(
        .CODE_W       (CODE_W),
        .THR_RESET    (THR_RESET),
        .FINAL_OFFSET (FINAL_OFFSET)
    ) u_thr (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (thr_wr_en),
        .wr_data   (thr_wr_data),
        .thr_first (level_thr[LVL_FIRST]),
        .thr_final (level_thr[LVL_FINAL])
    );

    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_level
        logic below;
        assign below = (smp_code < level_thr[g]);

        eodv_run_qual #(
            .RUN_LEN (RUN_LEN)
        ) u_qual (
            .clk       (clk),
            .rst       (rst),
            .sample_ok (smp_valid),
            .is_low    (below),
            .restart   (thr_wr_en),
            .tripped   (level_trip[g])
        );
    end

    assign thr_code   = level_thr[LVL_FIRST];
    assign warn_first = level_trip[LVL_FIRST];
    assign warn_final = level_trip[LVL_FINAL];

endmodule

// File: rtl/eodv_monitor_checker.sv
module eodv_monitor_checker #(
    parameter int unsigned        CODE_W    = 8,
    parameter logic [CODE_W-1:0]  THR_RESET = 8'hA2
) (
    input logic              clk,
    input logic              rst,
    input logic              smp_valid,
    input logic [CODE_W-1:0] smp_code,
    input logic              thr_wr_en,
    input logic [CODE_W-1:0] thr_wr_data,
    input logic [CODE_W-1:0] thr_code,
    input logic              warn_first,
    input logic              warn_final
);

    // R1: reset brings default threshold and clear flags
    a_r1_reset_values: assert property (@(posedge clk)
        rst |=> (thr_code == THR_RESET) && !warn_first && !warn_final);

    // R2: a write is read back on the next cycle
    a_r2_write_readback: assert property (@(posedge clk) disable iff (rst)
        thr_wr_en |=> thr_code == $past(thr_wr_data));

    // R2: without a write the threshold holds
    a_r2_thr_holds: assert property (@(posedge clk) disable iff (rst)
        !thr_wr_en |=> $stable(thr_code));

    // R7: both flags are sticky
    a_r7_first_sticky: assert property (@(posedge clk) disable iff (rst)
        warn_first |=> warn_first);

    a_r7_final_sticky: assert property (@(posedge clk) disable iff (rst)
        warn_final |=> warn_final);

    // R6: no flag rises in a cycle without a sample
    a_r6_no_rise_idle: assert property (@(posedge clk) disable iff (rst)
        (!smp_valid && !warn_first) |=> !warn_first);

    // R10: a sample at or above the first threshold cannot raise the first flag
    a_r10_high_no_rise: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && (smp_code >= thr_code) && !warn_first) |=> !warn_first);

    // R4: any run below the final level is also a run below the first level
    a_r4_final_implies_first: assert property (@(posedge clk) disable iff (rst)
        warn_final |-> warn_first);

endmodule

bind eodv_monitor eodv_monitor_checker #(
    .CODE_W    (CODE_W),
    .THR_RESET (THR_RESET)
) u_chk (.*);

// File: tb/eodv_monitor_bench.sv
module eodv_monitor_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       smp_valid = 1'b0;
    logic [7:0] smp_code = '0;
    logic       thr_wr_en = 1'b0;
    logic [7:0] thr_wr_data = '0;
    logic [7:0] thr_code;
    logic       warn_first;
    logic       warn_final;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    eodv_monitor u_eodv_monitor (
        .clk         (clk),
        .rst         (rst),
        .smp_valid   (smp_valid),
        .smp_code    (smp_code),
        .thr_wr_en   (thr_wr_en),
        .thr_wr_data (thr_wr_data),
        .thr_code    (thr_code),
        .warn_first  (warn_first),
        .warn_final  (warn_final)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic send(input logic [7:0] code, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            smp_valid = 1'b1;
            smp_code  = code;
            @(negedge clk);
            smp_valid = 1'b0;
        end
    endtask

    task automatic write_thr(input logic [7:0] val, input bit with_sample,
                             input logic [7:0] code);
        @(negedge clk);
        thr_wr_en   = 1'b1;
        thr_wr_data = val;
        smp_valid   = with_sample;
        smp_code    = code;
        @(negedge clk);
        thr_wr_en   = 1'b0;
        smp_valid   = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 thr_code", thr_code, 8'hA2);
        chk("R1 warn_first", warn_first, 0);
        chk("R1 warn_final", warn_final, 0);
    endtask

    // 150 is below 162 but above 141
    task automatic t_first_run();
        do_reset();
        send(8'd150, 7);
        chk("R3 after 7", warn_first, 0);
        send(8'd150, 1);
        chk("R3 after 8", warn_first, 1);
        chk("R4 final untouched at 150", warn_final, 0);
    endtask

    task automatic t_equal();
        do_reset();
        send(8'd162, 8);
        chk("R10 equal first", warn_first, 0);
        send(8'd141, 8);
        chk("R10 first set by 141", warn_first, 1);
        chk("R10 equal final", warn_final, 0);
    endtask

    task automatic t_break();
        do_reset();
        send(8'd150, 7);
        send(8'd200, 1);
        send(8'd150, 7);
        chk("R5 broken run", warn_first, 0);
        send(8'd150, 1);
        chk("R5 8 after break", warn_first, 1);
    endtask

    task automatic t_gaps();
        do_reset();
        send(8'd150, 4);
        repeat (10) @(negedge clk);
        send(8'd150, 3);
        chk("R6 7 with gap", warn_first, 0);
        send(8'd150, 1);
        chk("R6 8 with gap", warn_first, 1);
    endtask

    task automatic t_final();
        do_reset();
        send(8'd100, 7);
        chk("R4 final after 7", warn_final, 0);
        send(8'd100, 1);
        chk("R4 final after 8", warn_final, 1);
        chk("R3 first with final", warn_first, 1);
    endtask

    task automatic t_sticky();
        // continues from t_final: both flags set
        send(8'd200, 10);
        chk("R7 first after highs", warn_first, 1);
        chk("R7 final after highs", warn_final, 1);
        write_thr(8'd0, 1'b0, 8'd0);
        chk("R2 readback 0", thr_code, 0);
        chk("R8 first kept on write", warn_first, 1);
        chk("R8 final kept on write", warn_final, 1);
    endtask

    task automatic t_write_clear();
        do_reset();
        send(8'd150, 7);
        write_thr(8'hA2, 1'b1, 8'd150);
        chk("R2 readback A2", thr_code, 8'hA2);
        send(8'd150, 7);
        chk("R8 run restarted", warn_first, 0);
        send(8'd150, 1);
        chk("R8 8 after write", warn_first, 1);
    endtask

    task automatic t_clamp();
        do_reset();
        write_thr(8'd20, 1'b0, 8'd0);
        chk("R2 readback 20", thr_code, 20);
        send(8'd0, 8);
        chk("R9 first at 20", warn_first, 1);
        chk("R9 final clamped", warn_final, 0);
        do_reset();
        write_thr(8'd22, 1'b0, 8'd0);
        send(8'd0, 8);
        chk("R4 final at 22", warn_final, 1);
    endtask

    initial begin
        t_reset();
        t_first_run();
        t_equal();
        t_break();
        t_gaps();
        t_final();
        t_sticky();
        t_write_clear();
        t_clamp();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule